// File: doc/BRIEF.md
# Pixel and Load Clock Divider Chain

This block turns one fast clock into three related waveforms for a video output path: a main pixel clock, a load clock for the DAC and a slower secondary clock. All of the logic runs on the fast clock. Each output is a registered level that toggles on chosen cycles. The fast clock stands in for the VCO. The "direct" pixel wave toggles on every fast-clock cycle, so one pixel period equals two fast-clock cycles.

A post-scaler picks the pixel wave. The choices are the direct wave, the direct wave divided by two, the direct wave divided by four, or a board-test mode in which static bits drive the outputs. The load divider counts both edges of the post-scaler output and toggles once every N edges. Each half period of the load clock is therefore N pixel half periods long, and the duty cycle stays at 50% for odd N as well. The secondary divider counts load-clock edges in the same way, with a modulus from 1 to 512. A shift-clock gate can start and stop the secondary output from a blank input. The gate changes state only while both the load wave and the secondary wave are low. A new post-scaler select, load modulus or secondary modulus waits for a clean boundary before it takes effect.

Top module: `pixclk_chain`

## Requirements
- R1: During reset all three outputs are low. After reset, the post-scaler uses the direct wave and the load modulus is 4, whatever the select and modulus inputs hold. In direct mode with modulus 4, the first load high phase covers samples 4 to 7 after reset release.
- R2: Post-scaler select encoding is 0 = direct (pixel toggles every cycle), 1 = half rate (high and low 2 cycles each), 2 = quarter rate (4 cycles each) and 3 = board test. A new select takes effect only when the internal 3-bit phase counter wraps, which happens every 8 cycles.
- R3: The load modulus code maps 0,1,2,3,4,5 to N = 3,4,5,6,8,10, and codes 6 and 7 map to 4. Load high and low phases each last N pixel half periods, including for odd N.
- R4: The load divider is fed from the post-scaler output. Load run lengths scale with the post-scaler rate, and every load edge falls in a cycle where the pixel output also changes.
- R5: The secondary limit field holds M-1. Secondary high and low phases each last M load half periods, and the secondary wave changes only in a cycle where the load wave changes. With M = 1 the secondary output equals the load output.
- R6: A new load modulus is adopted only at the falling edge of the load wave. The load phase already in progress keeps the old modulus.
- R7: With the load-off bit set outside board test, the load output stays low while the secondary output keeps running.
- R8: In board test (select 3), the pixel and load outputs follow the two static bits, one cycle later.
- R9: With shift-clock enable set and M = 1, a high blank lets the secondary output run equal to the load output, and a low blank holds it low. The gate changes only while load and secondary are both low, so every secondary high pulse is full length.
- R10: With shift-clock enable clear, the blank input has no effect on the secondary output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock |
| rst | input | 1 | Synchronous active-high reset |
| ps_sel | input | 2 | Post-scaler select: 0 direct, 1 half, 2 quarter, 3 board test |
| aux_pix | input | 1 | Static pixel level in board test |
| aux_load | input | 1 | Static load level in board test |
| ld_code | input | 3 | Load modulus code (3,4,5,6,8,10; 6 and 7 give 4) |
| ld_off | input | 1 | Forces the load output low |
| sec_lim | input | SEC_W | Secondary modulus minus one |
| sc_en | input | 1 | Shift-clock gate enable |
| blank | input | 1 | High lets the secondary output run when gating is enabled |
| pix_o | output | 1 | Pixel clock wave |
| load_o | output | 1 | Load clock wave |
| sec_o | output | 1 | Secondary clock wave |

## Verification
The edge-alignment and runt-free properties assume that the shift-clock enable and the load-off bit change only between measured windows. They also assume that board test is entered and left only at a phase-counter wrap, and the select boundary guarantees this. The stimulus changes these control fields only after a sample point. It then waits several full output periods before it measures run lengths, so the measured phases come from one settled configuration. Blank is switched both during a load high phase and during a load low phase, which exercises the deferred gate update against live edges.

// File: rtl/pixclk_pkg.sv
package pixclk_pkg;
  typedef enum logic [1:0] {
    PS_DIRECT  = 2'd0,
    PS_HALF    = 2'd1,
    PS_QUARTER = 2'd2,
    PS_TEST    = 2'd3
  } ps_sel_e;

  localparam int LD_W = 4;
  localparam logic [LD_W-1:0] LD_RST_LIM = LD_W'(3);

  // Load modulus code to terminal count (modulus minus one).
  function automatic logic [LD_W-1:0] ld_lim_f(input logic [2:0] code);
    case (code)
      3'd0:    ld_lim_f = LD_W'(2);
      3'd1:    ld_lim_f = LD_W'(3);
      3'd2:    ld_lim_f = LD_W'(4);
      3'd3:    ld_lim_f = LD_W'(5);
      3'd4:    ld_lim_f = LD_W'(7);
      3'd5:    ld_lim_f = LD_W'(9);
      default: ld_lim_f = LD_W'(3);
    endcase
  endfunction
endpackage

// File: rtl/pixclk_postscale.sv
module pixclk_postscale
  import pixclk_pkg::*;
#(
  parameter int PH_W = 3
) (
  input  logic    clk,
  input  logic    rst,
  input  logic [1:0] ps_sel,
  output ps_sel_e sel_act,
  output ps_sel_e sel_nxt,
  output logic    pst_nxt,
  output logic    pst_edge
);
  logic [PH_W-1:0] ph;
  logic [PH_W-1:0] ph_n;
  logic            wrap;
  logic            pst_q;

  assign ph_n = ph + 1'b1;
  assign wrap = (ph == {PH_W{1'b1}});
  assign sel_nxt = wrap ? ps_sel_e'(ps_sel) : sel_act;

  always_comb begin
    case (sel_nxt)
      PS_DIRECT:  pst_nxt = ph_n[0];
      PS_HALF:    pst_nxt = ph_n[1];
      PS_QUARTER: pst_nxt = ph_n[2];
      default:    pst_nxt = 1'b0;
    endcase
  end

  assign pst_edge = pst_nxt ^ pst_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph      <= '0;
      sel_act <= PS_DIRECT;
      pst_q   <= 1'b0;
    end else begin
      ph      <= ph_n;
      sel_act <= sel_nxt;
      pst_q   <= pst_nxt;
    end
  end
endmodule

// File: rtl/pixclk_edge_div.sv
module pixclk_edge_div #(
  parameter int CW = 4,
  parameter logic [CW-1:0] RST_LIM = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  input  logic [CW-1:0] lim_in,
  output logic          wave_q,
  output logic          wave_nxt
);
  logic [CW-1:0] cnt;
  logic [CW-1:0] lim_act;
  logic          term;

  assign term     = step && (cnt == lim_act);
  assign wave_nxt = wave_q ^ term;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      lim_act <= RST_LIM;
      wave_q  <= 1'b0;
    end else begin
      if (step) cnt <= term ? '0 : cnt + 1'b1;
      if (term) begin
        wave_q <= ~wave_q;
        if (wave_q) lim_act <= lim_in;
      end
    end
  end
endmodule

// File: rtl/pixclk_sc_gate.sv
module pixclk_sc_gate (
  input  logic clk,
  input  logic rst,
  input  logic sc_en,
  input  logic blank,
  input  logic ld_nxt,
  input  logic sec_nxt,
  output logic sec_g_nxt
);
  logic gate_q;
  logic gate_nxt;
  logic open_win;

  assign open_win  = !ld_nxt && !sec_nxt;
  assign gate_nxt  = open_win ? blank : gate_q;
  assign sec_g_nxt = sec_nxt & (gate_nxt | ~sc_en);

  always_ff @(posedge clk) begin
    if (rst) gate_q <= 1'b0;
    else     gate_q <= gate_nxt;
  end
endmodule

// File: rtl/pixclk_chain.sv
module pixclk_chain
  import pixclk_pkg::*;
#(
  parameter int SEC_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       ps_sel,
  input  logic             aux_pix,
  input  logic             aux_load,
  input  logic [2:0]       ld_code,
  input  logic             ld_off,
  input  logic [SEC_W-1:0] sec_lim,
  input  logic             sc_en,
  input  logic             blank,
  output logic             pix_o,
  output logic             load_o,
  output logic             sec_o
);
  ps_sel_e         sel_act;
  ps_sel_e         sel_nxt;
  logic            pst_nxt;
  logic            pst_edge;
  logic [LD_W-1:0] ld_lim;
  logic            ld_wave;
  logic            ld_nxt;
  logic            ld_tgl;
  logic            sec_wave;
  logic            sec_nxt;
  logic            sec_g_nxt;

  assign ld_lim = ld_lim_f(ld_code);
  assign ld_tgl = ld_nxt ^ ld_wave;

  pixclk_postscale u_ps (
    .clk(clk), .rst(rst), .ps_sel(ps_sel),
    .sel_act(sel_act), .sel_nxt(sel_nxt),
    .pst_nxt(pst_nxt), .pst_edge(pst_edge)
  );

  pixclk_edge_div #(.CW(LD_W), .RST_LIM(LD_RST_LIM)) u_ld (
    .clk(clk), .rst(rst), .step(pst_edge), .lim_in(ld_lim),
    .wave_q(ld_wave), .wave_nxt(ld_nxt)
  );

  pixclk_edge_div #(.CW(SEC_W), .RST_LIM('0)) u_sec (
    .clk(clk), .rst(rst), .step(ld_tgl), .lim_in(sec_lim),
    .wave_q(sec_wave), .wave_nxt(sec_nxt)
  );

  pixclk_sc_gate u_gate (
    .clk(clk), .rst(rst), .sc_en(sc_en), .blank(blank),
    .ld_nxt(ld_nxt), .sec_nxt(sec_nxt), .sec_g_nxt(sec_g_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pix_o  <= 1'b0;
      load_o <= 1'b0;
      sec_o  <= 1'b0;
    end else begin
      if (sel_nxt == PS_TEST) begin
        pix_o  <= aux_pix;
        load_o <= aux_load;
      end else begin
        pix_o  <= pst_nxt;
        load_o <= ld_nxt & ~ld_off;
      end
      sec_o <= sec_g_nxt;
    end
  end
endmodule

// File: rtl/pixclk_chain_chk.sv
module pixclk_chain_chk
  import pixclk_pkg::*;
(
  input logic    clk,
  input logic    rst,
  input logic    sc_en,
  input logic    ld_off,
  input logic    aux_pix,
  input logic    pix_o,
  input logic    load_o,
  input logic    sec_o,
  input ps_sel_e sel_act,
  input logic    ld_wave,
  input logic    sec_wave
);
  AST_LOAD_ON_PIX_EDGE: assert property (@(posedge clk) disable iff (rst)
    ($changed(ld_wave) && sel_act != PS_TEST) |-> $changed(pix_o)); // R4

  AST_SEC_ON_LOAD_EDGE: assert property (@(posedge clk) disable iff (rst)
    $changed(sec_wave) |-> $changed(ld_wave)); // R5

  AST_LOAD_OFF_LOW: assert property (@(posedge clk) disable iff (rst)
    ($past(ld_off) && sel_act != PS_TEST) |-> !load_o); // R7

  AST_TEST_PIX: assert property (@(posedge clk) disable iff (rst)
    (sel_act == PS_TEST) |-> (pix_o == $past(aux_pix))); // R8

  AST_SEC_RISE_CLEAN: assert property (@(posedge clk) disable iff (rst)
    ($rose(sec_o) && $past(sc_en, 2) == $past(sc_en)) |-> $changed(ld_wave)); // R9

  AST_SEC_FALL_CLEAN: assert property (@(posedge clk) disable iff (rst)
    ($fell(sec_o) && $past(sc_en, 2) == $past(sc_en)) |-> $changed(ld_wave)); // R9
endmodule

bind pixclk_chain pixclk_chain_chk i_chk (
  .clk(clk), .rst(rst), .sc_en(sc_en), .ld_off(ld_off), .aux_pix(aux_pix),
  .pix_o(pix_o), .load_o(load_o), .sec_o(sec_o),
  .sel_act(sel_act), .ld_wave(ld_wave), .sec_wave(sec_wave)
);

// File: tb/test_pixclk_chain.sv
`timescale 1ns/1ps
module test_pixclk_chain;
  localparam int SEC_W = 9;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] ps_sel = 2'd0;
  logic aux_pix = 1'b0;
  logic aux_load = 1'b0;
  logic [2:0] ld_code = 3'd1;
  logic ld_off = 1'b0;
  logic [SEC_W-1:0] sec_lim = '0;
  logic sc_en = 1'b0;
  logic blank = 1'b1;
  logic pix_o, load_o, sec_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pixclk_chain #(.SEC_W(SEC_W)) i_pixclk_chain (
    .clk(clk), .rst(rst), .ps_sel(ps_sel), .aux_pix(aux_pix),
    .aux_load(aux_load), .ld_code(ld_code), .ld_off(ld_off),
    .sec_lim(sec_lim), .sc_en(sc_en), .blank(blank),
    .pix_o(pix_o), .load_o(load_o), .sec_o(sec_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  function automatic logic pick(input int w);
    case (w)
      0:       return pix_o;
      1:       return load_o;
      default: return sec_o;
    endcase
  endfunction

  task automatic wait_rise(input int w);
    logic p;
    int g = 0;
    p = pick(w);
    do begin
      tick();
      g++;
      if (!p && pick(w)) break;
      p = pick(w);
    end while (g < 40000);
  endtask

  task automatic run_len(input int w, output int n);
    logic v;
    v = pick(w);
    n = 0;
    while (pick(w) == v && n < 40000) begin
      n++;
      tick();
    end
  endtask

  task automatic runs(input int w, output int hi, output int lo);
    wait_rise(w);
    run_len(w, hi);
    run_len(w, lo);
  endtask

  task automatic settled(input int w, output int hi, output int lo);
    for (int k = 0; k < 3; k++) runs(w, hi, lo);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) tick();
    chk("R1 pix low in reset", pix_o, 0);
    chk("R1 load low in reset", load_o, 0);
    chk("R1 sec low in reset", sec_o, 0);
    rst = 1'b0;
  endtask

  task automatic t_reset_direct();
    logic [1:12] pv, lv, sv;
    ps_sel = 2'd0; ld_code = 3'd4; sec_lim = '0; sc_en = 1'b0;
    blank = 1'b1; ld_off = 1'b0;
    do_reset();
    for (int s = 1; s <= 12; s++) begin
      tick();
      pv[s] = pix_o; lv[s] = load_o; sv[s] = sec_o;
    end
    chk("R1 pix sample1", pv[1], 1);
    chk("R1 pix sample2", pv[2], 0);
    chk("R1 load sample3", lv[3], 0);
    chk("R1 load sample4", lv[4], 1);
    chk("R1 load sample7", lv[7], 1);
    chk("R1 load sample8", lv[8], 0);
    chk("R5 sec equals load sample4", sv[4], 1);
  endtask

  task automatic t_reset_quarter();
    logic [1:12] pv;
    ps_sel = 2'd2;
    do_reset();
    for (int s = 1; s <= 12; s++) begin
      tick();
      pv[s] = pix_o;
    end
    chk("R1 direct before wrap s1", pv[1], 1);
    chk("R1 direct before wrap s2", pv[2], 0);
    chk("R2 quarter after wrap s8", pv[8], 0);
    chk("R2 quarter after wrap s11", pv[11], 0);
    chk("R2 quarter after wrap s12", pv[12], 1);
  endtask

  task automatic t_presc();
    int hi, lo;
    ld_code = 3'd0;
    for (int m = 0; m < 3; m++) begin
      ps_sel = 2'(m);
      settled(0, hi, lo);
      chk($sformatf("R2 pix high sel%0d", m), hi, 1 << m);
      chk($sformatf("R2 pix low sel%0d", m), lo, 1 << m);
    end
  endtask

  task automatic t_load_mod();
    int hi, lo;
    int expn[8] = '{3, 4, 5, 6, 8, 10, 4, 4};
    ps_sel = 2'd0;
    for (int c = 0; c < 8; c++) begin
      ld_code = 3'(c);
      settled(1, hi, lo);
      chk($sformatf("R3 load high code%0d", c), hi, expn[c]);
      chk($sformatf("R3 load low code%0d", c), lo, expn[c]);
    end
  endtask

  task automatic t_load_src();
    int hi, lo, mism;
    logic pp, pl;
    ps_sel = 2'd1; ld_code = 3'd2;
    settled(1, hi, lo);
    chk("R4 load high half rate N5", hi, 10);
    chk("R4 load low half rate N5", lo, 10);
    ps_sel = 2'd2; ld_code = 3'd0;
    settled(1, hi, lo);
    chk("R4 load high quarter rate N3", hi, 12);
    chk("R4 load low quarter rate N3", lo, 12);
    mism = 0;
    pp = pix_o; pl = load_o;
    for (int s = 0; s < 100; s++) begin
      tick();
      if (load_o != pl && pix_o == pp) mism++;
      pp = pix_o; pl = load_o;
    end
    chk("R4 load edges on pix edges", mism, 0);
  endtask

  task automatic t_sec();
    int hi, lo, mism;
    ps_sel = 2'd0; ld_code = 3'd0; sec_lim = '0; sc_en = 1'b0;
    settled(2, hi, lo);
    mism = 0;
    for (int s = 0; s < 40; s++) begin
      tick();
      if (sec_o != load_o) mism++;
    end
    chk("R5 sec equals load for M1", mism, 0);
    ps_sel = 2'd1; ld_code = 3'd1; sec_lim = SEC_W'(1);
    settled(2, hi, lo);
    chk("R5 sec high M2 N4 half", hi, 16);
    chk("R5 sec low M2 N4 half", lo, 16);
    ps_sel = 2'd0; ld_code = 3'd0; sec_lim = SEC_W'(511);
    settled(2, hi, lo);
    chk("R5 sec high M512 N3", hi, 1536);
    chk("R5 sec low M512 N3", lo, 1536);
    sec_lim = '0;
    settled(2, hi, lo);
  endtask

  task automatic t_mod_change();
    int hi, lo;
    ps_sel = 2'd0; ld_code = 3'd0;
    settled(1, hi, lo);
    wait_rise(1);
    ld_code = 3'd3;
    run_len(1, hi);
    run_len(1, lo);
    chk("R6 current high keeps old N3", hi, 3);
    chk("R6 next low uses new N6", lo, 6);
    run_len(1, hi);
    chk("R6 next high uses new N6", hi, 6);
  endtask

  task automatic t_ld_off();
    int hi, lo, ones;
    ps_sel = 2'd0; ld_code = 3'd0; sec_lim = '0;
    settled(1, hi, lo);
    ld_off = 1'b1;
    tick();
    ones = 0;
    for (int s = 0; s < 30; s++) begin
      tick();
      if (load_o) ones++;
    end
    chk("R7 load held low", ones, 0);
    runs(2, hi, lo);
    chk("R7 sec keeps running", hi, 3);
    ld_off = 1'b0;
  endtask

  task automatic t_test_mode();
    int chg;
    logic pp;
    ps_sel = 2'd3; aux_pix = 1'b1; aux_load = 1'b0;
    repeat (10) tick();
    chk("R8 pix follows aux 1", pix_o, 1);
    chk("R8 load follows aux 0", load_o, 0);
    aux_pix = 1'b0; aux_load = 1'b1;
    tick();
    chk("R8 pix follows aux 0", pix_o, 0);
    chk("R8 load follows aux 1", load_o, 1);
    chg = 0; pp = pix_o;
    for (int s = 0; s < 12; s++) begin
      tick();
      if (pix_o != pp) chg++;
      pp = pix_o;
    end
    chk("R8 pix static in test", chg, 0);
    ps_sel = 2'd0; aux_load = 1'b0;
    repeat (10) tick();
  endtask

  task automatic t_blank();
    int hi, lo, mism, n, ones;
    ps_sel = 2'd0; ld_code = 3'd0; sec_lim = '0; sc_en = 1'b1; blank = 1'b1;
    settled(2, hi, lo);
    mism = 0;
    for (int s = 0; s < 30; s++) begin
      tick();
      if (sec_o != load_o) mism++;
    end
    chk("R9 blank high sec equals load", mism, 0);
    wait_rise(1);
    blank = 1'b0;
    run_len(2, n);
    chk("R9 stop keeps full high pulse", n, 3);
    ones = 0;
    for (int s = 0; s < 20; s++) begin
      tick();
      if (sec_o) ones++;
    end
    chk("R9 blank low holds sec low", ones, 0);
    wait_rise(1);
    blank = 1'b1;
    ones = 0;
    while (load_o) begin
      if (sec_o) ones++;
      tick();
    end
    chk("R9 no start mid high", ones, 0);
    runs(2, hi, lo);
    chk("R9 restart high full", hi, 3);
    chk("R9 restart low full", lo, 3);
  endtask

  task automatic t_blank_off();
    int hi, lo;
    sc_en = 1'b0; blank = 1'b0;
    settled(2, hi, lo);
    chk("R10 blank ignored high", hi, 3);
    chk("R10 blank ignored low", lo, 3);
    blank = 1'b1;
  endtask

  initial begin
    tick();
    t_reset_direct();
    t_reset_quarter();
    t_presc();
    t_load_mod();
    t_load_src();
    t_sec();
    t_mod_change();
    t_ld_off();
    t_test_mode();
    t_blank();
    t_blank_off();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule